// File: doc/BRIEF.md
# Dual-Port USB 2.0 PHY Power Sequencer

This controller powers up and powers down a USB 2.0 PHY that carries one or two ports. The ports share a reference clock enable and an active-low power-on reset. Each port has its own UTMI reset. A start strobe with a port index brings the shared resources up when they are not yet up. The bring-up runs in this order: clock on, power-on reset released, then a single three-step write through the PHY's serial test-register port to turn on the PHY clock. After that the selected port leaves UTMI reset. A fixed settling wait follows each step. The controller converts each wait from microseconds into system-clock cycles at elaboration time, using the clock frequency parameter.

A stop strobe puts the named port back into UTMI reset. If no other port is still running, the controller then asserts power-on reset, clears the test-port word and switches the reference clock off, one clock cycle apart. A second port can be started while the first is up. Only its UTMI reset is released and its wait is run. `busy_o` shows that a sequence is in flight. `done_o` pulses for one cycle when a sequence ends.

The test-port word has these fields: data in bits [7:0], register address in [15:8], target port in [18:16], write enable in bit 21, write strobe (active on its rising edge) in bit 22 and an active-low test reset in bit 23. The setup write always targets port 0, register 0x06, with data 0x04.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset, `ref_clk_en_o`=0, `por_n_o`=0, `utmi_rst_o`=2'b11, `tport_word_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A start accepted while everything is off sets `ref_clk_en_o` and `busy_o` on the accepting edge. `por_n_o` rises N_REF cycles later. Each N_x is floor(CLK_HZ·t/10^6) with a minimum of 1, where t is 100 us for N_REF, 300 us for N_POR, 2000 us for N_PHY and 2000 us for N_UTMI.
- R3: N_POR cycles after `por_n_o` rises, `tport_word_o` steps through 0xA00604, 0xE00604 and 0xA00604, holding each value for STEP_CYCLES cycles. The word then stays at 0xA00604 while powered. The port field is 0 whichever port was requested.
- R4: N_PHY cycles after the third write step begins plus STEP_CYCLES, the requested port's UTMI reset bit goes to 0. N_UTMI cycles later `busy_o` falls and `done_o` is high for exactly one cycle.
- R5: A start for a port that is still in UTMI reset, while the block is up and idle, releases only that port's UTMI reset on the accepting edge. It then raises `busy_o` for N_UTMI cycles and pulses `done_o`. The shared outputs and the word do not change.
- R6: A stop for a running port while another port keeps running sets that port's UTMI reset bit and pulses `done_o` on the accepting edge. Nothing else changes.
- R7: A stop for the last running port sets its UTMI reset bit on the accepting edge. On the next edge `por_n_o` goes to 0 and the word goes to 0. On the edge after that `ref_clk_en_o` goes to 0, `busy_o` falls and `done_o` pulses.
- R8: Start and stop strobes have no effect while `busy_o` is high. A start for a port that is already running has no effect. A stop for a port that is in UTMI reset has no effect.
- R9: With NUM_PORTS=1, `utmi_rst_o[1]` stays 1 and requests naming port 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for the port in `port_sel_i` |
| stop_i | input | 1 | Stop strobe for the port in `port_sel_i` |
| port_sel_i | input | 1 | Port index of the request |
| ref_clk_en_o | output | 1 | Shared reference clock enable |
| por_n_o | output | 1 | Shared power-on reset, active low |
| utmi_rst_o | output | 2 | Per-port UTMI reset, active high, bit n for port n |
| tport_word_o | output | 24 | Test-register port control word |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Any corrupted sequencing state shows at the ports within one settling window. A wrong wait count moves the edge of `por_n_o`, the test word or a UTMI reset by a measurable number of cycles. A wrong port register releases the other port's UTMI reset. A lost record of which ports are running turns a single-port stop into a full power-down, or the reverse, and this shows on the very next edge. The bench records the cycle number and the value of every change of the output vector, so an early or late transition is caught in the cycle it happens.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int TW_WIDTH      = 24;
  localparam int TW_DATA_LSB   = 0;
  localparam int TW_ADDR_LSB   = 8;
  localparam int TW_PORT_LSB   = 16;
  localparam int TW_WREN_BIT   = 21;
  localparam int TW_STROBE_BIT = 22;
  localparam int TW_RSTN_BIT   = 23;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_REF_WAIT,
    ST_POR_WAIT,
    ST_TP_WRITE,
    ST_PHY_WAIT,
    ST_UTMI_WAIT,
    ST_ON,
    ST_DN_POR,
    ST_DN_CLK
  } seq_state_e;

  typedef enum logic [1:0] {
    TP_IDLE,
    TP_LOW1,
    TP_HIGH,
    TP_LOW2
  } tp_phase_e;

  // microseconds -> cycles of a clock at hz, never below one cycle
  function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1000000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/pwrseq_rst_sync.sv
module pwrseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = value_i - CW'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_tport_writer.sv
module pwrseq_tport_writer
  import pwrseq_pkg::*;
#(
  parameter int          STEP_CYCLES = 4,
  parameter logic [7:0]  SETUP_ADDR  = 8'h06,
  parameter logic [7:0]  SETUP_DATA  = 8'h04,
  parameter logic [2:0]  SETUP_PORT  = 3'd0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic                clear_i,
  output logic [TW_WIDTH-1:0] word_o,
  output logic                done_o
);
  localparam int SW = $clog2(STEP_CYCLES + 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);

  function automatic logic [TW_WIDTH-1:0] build_word(logic strobe);
    logic [TW_WIDTH-1:0] w;
    w = '0;
    w[TW_DATA_LSB +: 8] = SETUP_DATA;
    w[TW_ADDR_LSB +: 8] = SETUP_ADDR;
    w[TW_PORT_LSB +: 3] = SETUP_PORT;
    w[TW_WREN_BIT]      = 1'b1;
    w[TW_RSTN_BIT]      = 1'b1;
    w[TW_STROBE_BIT]    = strobe;
    return w;
  endfunction

  localparam logic [TW_WIDTH-1:0] WORD_LOW  = build_word(1'b0);
  localparam logic [TW_WIDTH-1:0] WORD_HIGH = build_word(1'b1);

  tp_phase_e           phase_q, phase_d;
  logic [SW-1:0]       cnt_q, cnt_d;
  logic [TW_WIDTH-1:0] word_q, word_d;
  logic                step_end;

  assign step_end = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    if (clear_i) begin
      phase_d = TP_IDLE;
      cnt_d   = '0;
      word_d  = '0;
    end else if (go_i) begin
      phase_d = TP_LOW1;
      cnt_d   = STEP_LAST;
      word_d  = WORD_LOW;
    end else if (phase_q != TP_IDLE) begin
      if (!step_end) begin
        cnt_d = cnt_q - SW'(1);
      end else begin
        unique case (phase_q)
          TP_LOW1: begin phase_d = TP_HIGH; cnt_d = STEP_LAST; word_d = WORD_HIGH; end
          TP_HIGH: begin phase_d = TP_LOW2; cnt_d = STEP_LAST; word_d = WORD_LOW;  end
          default: begin phase_d = TP_IDLE; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TP_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
    end
  end

  assign word_o = word_q;
  assign done_o = (phase_q == TP_LOW2) && step_end;

  AST_STROBE_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[TW_STROBE_BIT] |-> (word_q[TW_WREN_BIT] && word_q[TW_RSTN_BIT])); // R3
  AST_CLEAR_ZEROES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (word_q == '0)); // R7
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int          NUM_PORTS = 2,
  parameter int          CW        = 16,
  parameter int unsigned N_REF     = 1,
  parameter int unsigned N_POR     = 1,
  parameter int unsigned N_PHY     = 1,
  parameter int unsigned N_UTMI    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          port_i,
  input  logic          tmr_expired_i,
  input  logic          wr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_value_o,
  output logic          wr_go_o,
  output logic          wr_clear_o,
  output logic          ref_en_o,
  output logic          por_n_o,
  output logic [1:0]    utmi_rst_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_state_e state_q, state_d;
  logic       ref_q, ref_d;
  logic       por_q, por_d;
  logic [1:0] utmi_q, utmi_d;
  logic       port_q, port_d;
  logic       done_q, done_d;
  logic       port_ok;
  logic [1:0] req_mask;
  logic       others_running;

  generate
    if (NUM_PORTS == 1) begin : g_single
      assign port_ok = ~port_i;
    end else begin : g_dual
      assign port_ok = 1'b1;
    end
  endgenerate

  assign req_mask       = port_i ? 2'b10 : 2'b01;
  assign others_running = ((~utmi_q) & ~req_mask) != 2'b00;

  always_comb begin
    state_d     = state_q;
    ref_d       = ref_q;
    por_d       = por_q;
    utmi_d      = utmi_q;
    port_d      = port_q;
    done_d      = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_value_o = '0;
    wr_go_o     = 1'b0;
    wr_clear_o  = 1'b0;
    unique case (state_q)
      ST_OFF: if (start_i && port_ok) begin
        state_d     = ST_REF_WAIT;
        ref_d       = 1'b1;
        port_d      = port_i;
        tmr_load_o  = 1'b1;
        tmr_value_o = CW'(N_REF);
      end
      ST_REF_WAIT: if (tmr_expired_i) begin
        state_d     = ST_POR_WAIT;
        por_d       = 1'b1;
        tmr_load_o  = 1'b1;
        tmr_value_o = CW'(N_POR);
      end
      ST_POR_WAIT: if (tmr_expired_i) begin
        state_d = ST_TP_WRITE;
        wr_go_o = 1'b1;
      end
      ST_TP_WRITE: if (wr_done_i) begin
        state_d     = ST_PHY_WAIT;
        tmr_load_o  = 1'b1;
        tmr_value_o = CW'(N_PHY);
      end
      ST_PHY_WAIT: if (tmr_expired_i) begin
        state_d         = ST_UTMI_WAIT;
        utmi_d[port_q]  = 1'b0;
        tmr_load_o      = 1'b1;
        tmr_value_o     = CW'(N_UTMI);
      end
      ST_UTMI_WAIT: if (tmr_expired_i) begin
        state_d = ST_ON;
        done_d  = 1'b1;
      end
      ST_ON: begin
        if (stop_i && port_ok && !utmi_q[port_i]) begin
          utmi_d[port_i] = 1'b1;
          if (others_running) done_d  = 1'b1;
          else                state_d = ST_DN_POR;
        end else if (start_i && port_ok && utmi_q[port_i]) begin
          state_d        = ST_UTMI_WAIT;
          port_d         = port_i;
          utmi_d[port_i] = 1'b0;
          tmr_load_o     = 1'b1;
          tmr_value_o    = CW'(N_UTMI);
        end
      end
      ST_DN_POR: begin
        state_d    = ST_DN_CLK;
        por_d      = 1'b0;
        wr_clear_o = 1'b1;
      end
      ST_DN_CLK: begin
        state_d = ST_OFF;
        ref_d   = 1'b0;
        done_d  = 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ref_q   <= 1'b0;
      por_q   <= 1'b0;
      utmi_q  <= 2'b11;
      port_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      por_q   <= por_d;
      utmi_q  <= utmi_d;
      port_q  <= port_d;
      done_q  <= done_d;
    end
  end

  assign ref_en_o   = ref_q;
  assign por_n_o    = por_q;
  assign utmi_rst_o = utmi_q;
  assign busy_o     = (state_q != ST_OFF) && (state_q != ST_ON);
  assign done_o     = done_q;

  AST_POR_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |-> ref_q); // R2
  AST_UTMI_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (utmi_q != 2'b11) |-> por_q); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_BUSY_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (start_i || stop_i)) |=> $stable(port_q)); // R8
  AST_PORT1_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_PORTS == 1) |-> utmi_q[1]); // R9
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int NUM_PORTS    = 2,
  parameter longint unsigned CLK_HZ = 125_000_000,
  parameter int REF_WAIT_US  = 100,
  parameter int POR_WAIT_US  = 300,
  parameter int PHY_WAIT_US  = 2000,
  parameter int UTMI_WAIT_US = 2000,
  parameter int STEP_CYCLES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                port_sel_i,
  output logic                ref_clk_en_o,
  output logic                por_n_o,
  output logic [1:0]          utmi_rst_o,
  output logic [TW_WIDTH-1:0] tport_word_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned N_REF  = us_to_cycles(CLK_HZ, longint'(REF_WAIT_US));
  localparam int unsigned N_POR  = us_to_cycles(CLK_HZ, longint'(POR_WAIT_US));
  localparam int unsigned N_PHY  = us_to_cycles(CLK_HZ, longint'(PHY_WAIT_US));
  localparam int unsigned N_UTMI = us_to_cycles(CLK_HZ, longint'(UTMI_WAIT_US));
  localparam int unsigned N_A    = (N_REF > N_POR) ? N_REF : N_POR;
  localparam int unsigned N_B    = (N_PHY > N_UTMI) ? N_PHY : N_UTMI;
  localparam int unsigned N_MAX  = (N_A > N_B) ? N_A : N_B;
  localparam int CW = $clog2(N_MAX + 1);

  logic          srst_n;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_value;
  logic          wr_go, wr_clear, wr_done;

  pwrseq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  pwrseq_timer #(.CW(CW)) u_tmr (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_i    (tmr_load),
    .value_i   (tmr_value),
    .expired_o (tmr_expired)
  );

  pwrseq_tport_writer #(.STEP_CYCLES(STEP_CYCLES)) u_wr (
    .clk     (clk),
    .rst_n   (srst_n),
    .go_i    (wr_go),
    .clear_i (wr_clear),
    .word_o  (tport_word_o),
    .done_o  (wr_done)
  );

  pwrseq_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .CW        (CW),
    .N_REF     (N_REF),
    .N_POR     (N_POR),
    .N_PHY     (N_PHY),
    .N_UTMI    (N_UTMI)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (srst_n),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .port_i        (port_sel_i),
    .tmr_expired_i (tmr_expired),
    .wr_done_i     (wr_done),
    .tmr_load_o    (tmr_load),
    .tmr_value_o   (tmr_value),
    .wr_go_o       (wr_go),
    .wr_clear_o    (wr_clear),
    .ref_en_o      (ref_clk_en_o),
    .por_n_o       (por_n_o),
    .utmi_rst_o    (utmi_rst_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  AST_WORD_ZERO_IN_POR: assert property (@(posedge clk) disable iff (!srst_n)
    !por_n_o |-> (tport_word_o == '0)); // R7
endmodule

// File: tb/sim_usbphy_pwr_seq.sv
module sim_usbphy_pwr_seq;
  localparam longint unsigned HZ = 1_000_000;
  localparam int STEP = 4;
  localparam int NR = int'(HZ * 100 / 1000000);
  localparam int NP = int'(HZ * 300 / 1000000);
  localparam int NH = int'(HZ * 2000 / 1000000);
  localparam int NU = int'(HZ * 2000 / 1000000);
  localparam logic [23:0] W_LOW  = 24'hA00604;
  localparam logic [23:0] W_HIGH = 24'hE00604;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start, stop, psel;
  logic ref_en, por_n, busy, done;
  logic [1:0] utmi;
  logic [23:0] word;

  logic start1, psel1;
  logic ref_en1, por_n1, busy1, done1;
  logic [1:0] utmi1;
  logic [23:0] word1;

  usbphy_pwr_seq #(.NUM_PORTS(2), .CLK_HZ(HZ), .STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .port_sel_i(psel),
    .ref_clk_en_o(ref_en), .por_n_o(por_n), .utmi_rst_o(utmi), .tport_word_o(word),
    .busy_o(busy), .done_o(done));

  usbphy_pwr_seq #(.NUM_PORTS(1), .CLK_HZ(HZ), .STEP_CYCLES(STEP)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .stop_i(1'b0), .port_sel_i(psel1),
    .ref_clk_en_o(ref_en1), .por_n_o(por_n1), .utmi_rst_o(utmi1), .tport_word_o(word1),
    .busy_o(busy1), .done_o(done1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  typedef struct { int t; logic [29:0] v; string tag; } exp_t;
  exp_t q[$];

  logic m_ref, m_por, m_busy, m_done;
  logic [1:0] m_utmi;
  logic [23:0] m_word;

  function automatic logic [29:0] snap();
    return {ref_en, por_n, utmi, busy, done, word};
  endfunction

  function automatic logic [29:0] model();
    return {m_ref, m_por, m_utmi, m_busy, m_done, m_word};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push(int t, string tag);
    exp_t e;
    e.t = t; e.v = model(); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: every change of the output vector must match the queue head
  bit mon_en = 0;
  logic [29:0] prev;
  always @(negedge clk) begin
    if (mon_en) begin
      logic [29:0] cur;
      cur = snap();
      if (cur !== prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected change", {2'b0, cur}, {2'b0, prev});
        end else begin
          exp_t e;
          e = q.pop_front();
          check((cur === e.v) && (cyc == e.t), e.tag, {2'b0, cur}, {2'b0, e.v});
          if (cyc != e.t) $display("     %s: change at cycle %0d, expected %0d", e.tag, cyc, e.t);
        end
      end
      prev = cur;
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(bit s, bit p, bit x);
    @(negedge clk);
    start = s; stop = x; psel = p;
    @(negedge clk);
    start = 0; stop = 0;
  endtask

  // full bring-up from off; push predictions, then strobe
  task automatic up_from_off(bit p);
    int c0, t;
    @(negedge clk);
    c0 = cyc + 1;
    m_ref = 1; m_busy = 1; push(c0, "R2");
    m_por = 1; push(c0 + NR, "R2");
    t = c0 + NR + NP;
    m_word = W_LOW;  push(t, "R3");
    m_word = W_HIGH; push(t + STEP, "R3");
    m_word = W_LOW;  push(t + 2 * STEP, "R3");
    t = t + 3 * STEP + NH;
    m_utmi[p] = 1'b0; push(t, "R4");
    m_busy = 0; m_done = 1; push(t + NU, "R4");
    m_done = 0; push(t + NU + 1, "R4");
    start = 1; psel = p;
    @(negedge clk);
    start = 0;
  endtask

  task automatic add_port(bit p);
    int c0;
    @(negedge clk);
    c0 = cyc + 1;
    m_utmi[p] = 1'b0; m_busy = 1; push(c0, "R5");
    m_busy = 0; m_done = 1; push(c0 + NU, "R5");
    m_done = 0; push(c0 + NU + 1, "R5");
    start = 1; psel = p;
    @(negedge clk);
    start = 0;
  endtask

  task automatic stop_keep(bit p);
    int c0;
    @(negedge clk);
    c0 = cyc + 1;
    m_utmi[p] = 1'b1; m_done = 1; push(c0, "R6");
    m_done = 0; push(c0 + 1, "R6");
    stop = 1; psel = p;
    @(negedge clk);
    stop = 0;
  endtask

  task automatic stop_last(bit p);
    int c0;
    @(negedge clk);
    c0 = cyc + 1;
    m_utmi[p] = 1'b1; m_busy = 1; push(c0, "R7");
    m_por = 0; m_word = '0; push(c0 + 1, "R7");
    m_ref = 0; m_busy = 0; m_done = 1; push(c0 + 2, "R7");
    m_done = 0; push(c0 + 3, "R7");
    stop = 1; psel = p;
    @(negedge clk);
    stop = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    start = 0; stop = 0; psel = 0; start1 = 0; psel1 = 0;
    m_ref = 0; m_por = 0; m_utmi = 2'b11; m_busy = 0; m_done = 0; m_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(snap() === model(), "R1 reset state", {2'b0, snap()}, {2'b0, model()});
    prev = snap();
    mon_en = 1;

    // R2..R4 bring-up of port 0; strobes during busy must be ignored (R8)
    up_from_off(1'b0);
    repeat (40) @(negedge clk);
    pulse(1, 1, 0);
    repeat (200) @(negedge clk);
    pulse(0, 0, 1);
    repeat (NR + NP + 2) @(negedge clk);
    pulse(1, 1, 1);
    drain();

    // R8: start of running port and stop of idle port in powered state
    pulse(1, 0, 0);
    pulse(0, 1, 1);
    repeat (20) @(negedge clk);
    check(snap() === model(), "R8 ignored requests", {2'b0, snap()}, {2'b0, model()});
    check(q.size() == 0, "R8 queue empty", q.size(), 0);

    // R5 second port; stop during its wait ignored (R8)
    add_port(1'b1);
    repeat (30) @(negedge clk);
    pulse(0, 0, 1);
    drain();
    check(utmi === 2'b00, "R5 both ports running", {30'b0, utmi}, 32'd0);

    // R6 stop one of two, R7 stop the last
    stop_keep(1'b0);
    drain();
    stop_last(1'b1);
    drain();
    check(word === 24'h0, "R7 word cleared", {8'b0, word}, 32'd0);

    // R3: port 1 bring-up still writes port field 0; then R7 again
    up_from_off(1'b1);
    drain();
    check(word[18:16] === 3'd0, "R3 port field", {29'b0, word[18:16]}, 32'd0);
    stop_last(1'b1);
    drain();
    mon_en = 0;

    // R9: single-port instance
    @(negedge clk); start1 = 1; psel1 = 1;
    @(negedge clk); start1 = 0;
    repeat (10) @(negedge clk);
    check(!busy1 && !ref_en1 && utmi1 === 2'b11, "R9 port 1 request ignored",
          {27'b0, busy1, ref_en1, utmi1, por_n1}, 32'b00110);
    @(negedge clk); start1 = 1; psel1 = 0;
    @(negedge clk); start1 = 0;
    repeat (NR + NP + 3 * STEP + NH + NU + 5) @(negedge clk);
    check(utmi1 === 2'b10 && por_n1 && !busy1, "R9 port 0 up, port 1 held",
          {28'b0, utmi1, por_n1, busy1}, 32'b1010);
    check(word1 === W_LOW && !done1, "R9 word after setup", {8'b0, word1}, {8'b0, W_LOW});

    summary();
  end
endmodule